// File: doc/BRIEF.md
# Remote terminal command decoder

This block sits behind the word receiver of a serial command/response bus remote terminal. It takes a command word that has already been checked, together with a strobe and a flag naming the channel it came on. It compares the word's terminal address field with a locally held 5-bit address. A word addressed to this terminal or to the broadcast address (31) is accepted. One clock edge later the block presents registered decode outputs: transfer direction, broadcast, mode command, channel, message error, and a 16-bit last-command view.

The held terminal address is loaded from a pin bus. A load happens on an explicit load pulse, and on every cycle while the address-enable input is low. A single 5-bit output shows either the mode code or the subaddress of the last accepted command, as a select input chooses. An external qualifier can mark the presented command as illegal. A separate input reports a message-sequence error. Both set the message error flag.

Top module: `rt_cmd_decoder`

## Requirements
- R1: The terminal address register takes `addr_in` on every clock edge where `addr_load` is 1 or `addr_en` is 0, and holds its value otherwise. A command compares against the value held before that edge.
- R2: A command is accepted when `cmd_valid` is 1 and `cmd_word[15:11]` equals the held address or 31. A strobed command that is not accepted leaves every output except `msg_err` unchanged.
- R3: `mcsa_out` equals bits [4:0] of the last accepted command while `sel_sa` is 0, and bits [9:5] while `sel_sa` is 1. The path is combinational from `sel_sa`.
- R4: `mode_ind` is 1 only while `sel_sa` is 0 and the last accepted command had field [9:5] equal to 0 or 31.
- R5: `chan_a_out` takes the value of `cmd_chan_a` (1 means channel A, 0 means channel B) at each accepted command.
- R6: After an accepted legal command, `xmit_n` is 0 if bit 10 is 1 (transmit) and `rcv_n` is 0 if bit 10 is 0. After an illegal command both are 1. The two are never 0 together.
- R7: `bcast_n` is 0 after an accepted command with address 31, and 1 after any other accepted command.
- R8: An accepted command is illegal when `illegal_in` is 1 or it is a broadcast with bit 10 = 1. `msg_err` becomes 1 after an illegal command and 0 after a legal one (unless R9 applies).
- R9: `msg_err` becomes 1 on the edge after any cycle with `seq_err` = 1, including a cycle that also accepts a command. It stays 1 until a later accepted legal command.
- R10: `last_cmd` = {msg_err, illegal_in at accept, broadcast, mode, channel A, command bits [10:0]}.
- R11: In the cycle after a clock edge with `rst_n` = 0: `xmit_n`, `rcv_n` and `bcast_n` are 1; `msg_err`, `chan_a_out`, `mode_ind`, `mcsa_out` and `last_cmd` are 0; the held address is 0.
- R12: Decode outputs change only on the first clock edge after the accepting cycle, and hold while no command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | 5 | Terminal address pins |
| addr_load | input | 1 | Load pulse for the terminal address |
| addr_en | input | 1 | Address-enable; the address follows `addr_in` while this is low |
| cmd_valid | input | 1 | Strobe for a validated command word |
| cmd_word | input | 16 | Command word |
| cmd_chan_a | input | 1 | 1 = word received on channel A, 0 = channel B |
| illegal_in | input | 1 | Marks the strobed command as illegal |
| seq_err | input | 1 | Message-sequence error pulse |
| sel_sa | input | 1 | 0 selects the mode code, 1 selects the subaddress on `mcsa_out` |
| mcsa_out | output | 5 | Mode code or subaddress of the last command |
| mode_ind | output | 1 | Last command was a mode command (valid while `sel_sa` = 0) |
| chan_a_out | output | 1 | Channel of the last accepted command |
| msg_err | output | 1 | Message error flag, active high |
| xmit_n | output | 1 | Transmit transfer in progress, active low |
| rcv_n | output | 1 | Receive transfer in progress, active low |
| bcast_n | output | 1 | Broadcast received, active low |
| last_cmd | output | 16 | Status bits and low 11 bits of the last command |

## Verification
Registered results (direction, broadcast, channel, error and `last_cmd`) are due on the first rising edge after the accepting cycle. `mcsa_out` and `mode_ind` follow `sel_sa` in the same cycle. The bench drives every input on a falling edge and drops the strobe on the next falling edge, so one rising edge lies between them. It samples there, and samples again a few nanoseconds after each change of `sel_sa`. Address loads and sequence-error pulses use the same one-edge spacing, so each check falls one register stage after its cause.

// File: rtl/rtd_pkg.sv
// Package: shared widths and the command field layout for the decoder.
// Assumes a 16-bit command word with a 5-bit address field on top.
package rtd_pkg;
    localparam int FLD_W    = 5;
    localparam int CMD_W    = 16;
    localparam int LOW_W    = 11;
    localparam logic [FLD_W-1:0] BCAST_ADDR = '1;
    localparam logic [FLD_W-1:0] MODE_SA_LO = '0;
    localparam logic [FLD_W-1:0] MODE_SA_HI = '1;

    typedef struct packed {
        logic [FLD_W-1:0] rt;
        logic             tr;
        logic [FLD_W-1:0] sa;
        logic [FLD_W-1:0] wc;
    } cmd_fields_t;

    typedef struct packed {
        logic             match;
        logic             bcast;
        logic             mode;
        logic             bad;
        logic             tr;
    } cmd_dec_t;
endpackage

// File: rtl/rtd_addr_latch.sv
// Holds the terminal address. Loads from the pins on a load pulse or
// whenever the enable is low. Assumes synchronous active-low reset.
module rtd_addr_latch #(
    parameter int W = rtd_pkg::FLD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr_in,
    input  logic         load,
    input  logic         en,
    output logic [W-1:0] own_addr
);
    // Capture the pin address when loaded or transparent.
    always_ff @(posedge clk) begin
        if (!rst_n)
            own_addr <= '0;
        else if (load || !en)
            own_addr <= addr_in;
    end
endmodule

// File: rtl/rtd_field_decode.sv
// Combinational decode of a command word against the held address.
// Produces match, broadcast, mode and illegal flags. Assumes the
// command layout in rtd_pkg.
module rtd_field_decode
    import rtd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    input  logic [FLD_W-1:0] own_addr,
    input  logic             illegal_in,
    output cmd_dec_t         dec
);
    cmd_fields_t f;
    assign f = cmd_fields_t'(cmd_word);

    // Classify the word: addressed, broadcast, mode, illegal.
    always_comb begin
        dec.bcast = (f.rt == BCAST_ADDR);
        dec.match = dec.bcast || (f.rt == own_addr);
        dec.mode  = (f.sa == MODE_SA_LO) || (f.sa == MODE_SA_HI);
        dec.tr    = f.tr;
        dec.bad   = illegal_in || (dec.bcast && f.tr);
    end
endmodule

// File: rtl/rtd_state_regs.sv
// Registered decode state, updated on an accepted command. Also holds
// the sticky message error flag. Assumes dec is valid while cmd_valid is 1.
module rtd_state_regs
    import rtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [LOW_W-1:0] cmd_low,
    input  logic             cmd_chan_a,
    input  logic             illegal_in,
    input  logic             seq_err,
    input  cmd_dec_t         dec,
    output logic [LOW_W-1:0] low_q,
    output logic             chan_q,
    output logic             ill_q,
    output logic             bcast_q,
    output logic             mode_q,
    output logic             err_q,
    output logic             xmit_n,
    output logic             rcv_n
);
    logic accept;
    assign accept = cmd_valid && dec.match;

    // Snapshot of the accepted command and its decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            chan_q  <= 1'b0;
            ill_q   <= 1'b0;
            bcast_q <= 1'b0;
            mode_q  <= 1'b0;
            xmit_n  <= 1'b1;
            rcv_n   <= 1'b1;
        end else if (accept) begin
            low_q   <= cmd_low;
            chan_q  <= cmd_chan_a;
            ill_q   <= illegal_in;
            bcast_q <= dec.bcast;
            mode_q  <= dec.mode;
            xmit_n  <= !(dec.tr && !dec.bad);
            rcv_n   <= !(!dec.tr && !dec.bad);
        end
    end

    // Message error: recomputed on accept, sticky on sequence error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (accept)
            err_q <= dec.bad || seq_err;
        else if (seq_err)
            err_q <= 1'b1;
    end
endmodule

// File: rtl/rt_cmd_decoder.sv
// Top: remote terminal command decoder. Accepts validated command words
// addressed to this terminal or broadcast, and presents registered decode
// outputs. Assumes upstream has already checked sync, Manchester coding and parity.
module rt_cmd_decoder
    import rtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       addr_in,
    input  logic             addr_load,
    input  logic             addr_en,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd_word,
    input  logic             cmd_chan_a,
    input  logic             illegal_in,
    input  logic             seq_err,
    input  logic             sel_sa,
    output logic [4:0]       mcsa_out,
    output logic             mode_ind,
    output logic             chan_a_out,
    output logic             msg_err,
    output logic             xmit_n,
    output logic             rcv_n,
    output logic             bcast_n,
    output logic [15:0]      last_cmd
);
    logic [FLD_W-1:0] own_addr_q;
    cmd_dec_t         dec;
    logic [LOW_W-1:0] low_q;
    logic             chan_q, ill_q, bcast_q, mode_q, err_q;

    rtd_addr_latch #(.W(FLD_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .load(addr_load), .en(addr_en), .own_addr(own_addr_q)
    );

    rtd_field_decode u_dec (
        .cmd_word(cmd_word), .own_addr(own_addr_q),
        .illegal_in(illegal_in), .dec(dec)
    );

    rtd_state_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_low(cmd_word[LOW_W-1:0]), .cmd_chan_a(cmd_chan_a),
        .illegal_in(illegal_in), .seq_err(seq_err), .dec(dec),
        .low_q(low_q), .chan_q(chan_q), .ill_q(ill_q), .bcast_q(bcast_q),
        .mode_q(mode_q), .err_q(err_q), .xmit_n(xmit_n), .rcv_n(rcv_n)
    );

    // Output mux and status packing.
    always_comb begin
        mcsa_out   = sel_sa ? low_q[2*FLD_W-1:FLD_W] : low_q[FLD_W-1:0];
        mode_ind   = !sel_sa && mode_q;
        chan_a_out = chan_q;
        msg_err    = err_q;
        bcast_n    = !bcast_q;
        last_cmd   = {err_q, ill_q, bcast_q, mode_q, chan_q, low_q};
    end
endmodule

// File: rtl/rtd_checker.sv
// Checker for rt_cmd_decoder, attached by bind. Observes ports and the
// held address only.
module rtd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  addr_in,
    input logic        addr_load,
    input logic        addr_en,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        cmd_chan_a,
    input logic        seq_err,
    input logic        sel_sa,
    input logic [4:0]  mcsa_out,
    input logic        mode_ind,
    input logic        chan_a_out,
    input logic        msg_err,
    input logic        xmit_n,
    input logic        rcv_n,
    input logic        bcast_n,
    input logic [15:0] last_cmd,
    input logic [4:0]  own_addr
);
    logic acc;
    assign acc = cmd_valid && (cmd_word[15:11] == own_addr || cmd_word[15:11] == 5'd31);

    assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load || !addr_en) |=> own_addr == $past(addr_in));
    assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !acc) |=> $stable(last_cmd[14:0]) && $stable(xmit_n) && $stable(rcv_n));
    assert_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mcsa_out == (sel_sa ? last_cmd[9:5] : last_cmd[4:0]));
    assert_mode_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sa |-> !mode_ind);
    assert_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> chan_a_out == $past(cmd_chan_a));
    assert_xr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xmit_n && !rcv_n));
    assert_bcast_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_word[15:11] == 5'd31 && cmd_word[10]) |=> msg_err && xmit_n && !bcast_n);
    assert_seq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> msg_err);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(last_cmd[14:0]) && $stable(bcast_n) && $stable(xmit_n));
endmodule

bind rt_cmd_decoder rtd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .addr_load(addr_load),
    .addr_en(addr_en), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_chan_a(cmd_chan_a), .seq_err(seq_err), .sel_sa(sel_sa),
    .mcsa_out(mcsa_out), .mode_ind(mode_ind), .chan_a_out(chan_a_out),
    .msg_err(msg_err), .xmit_n(xmit_n), .rcv_n(rcv_n), .bcast_n(bcast_n),
    .last_cmd(last_cmd), .own_addr(own_addr_q)
);

// File: tb/sim_rt_cmd_decoder.sv
module sim_rt_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_in = 5'd9;
    logic        addr_load = 1'b0, addr_en = 1'b0;
    logic        cmd_valid = 1'b0, cmd_chan_a = 1'b0, illegal_in = 1'b0;
    logic        seq_err = 1'b0, sel_sa = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [4:0]  mcsa_out;
    logic        mode_ind, chan_a_out, msg_err, xmit_n, rcv_n, bcast_n;
    logic [15:0] last_cmd;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rt_cmd_decoder u0 (.*);

    // {cmd, chan, ill, acc, xmit_n, rcv_n, bcast_n, err, mode}
    localparam logic [23:0] VEC [8] = '{
        {16'h4C64, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {16'h48E0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {16'hF845, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {16'hFC41, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {16'h4C02, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {16'h4BF1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {16'h4881, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        {16'h5464, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input logic ch, input logic ill, input logic se);
        @(negedge clk);
        cmd_word = w; cmd_chan_a = ch; illegal_in = ill; cmd_valid = 1'b1; seq_err = se;
        @(negedge clk);
        cmd_valid = 1'b0; illegal_in = 1'b0; seq_err = 1'b0;
    endtask

    task automatic check_reset();
        chk("R11 xmit_n", {15'd0, xmit_n}, 16'd1);
        chk("R11 rcv_n", {15'd0, rcv_n}, 16'd1);
        chk("R11 bcast_n", {15'd0, bcast_n}, 16'd1);
        chk("R11 msg_err", {15'd0, msg_err}, 16'd0);
        chk("R11 chan", {15'd0, chan_a_out}, 16'd0);
        chk("R11 last_cmd", last_cmd, 16'd0);
        chk("R11 mcsa/mode", {10'd0, mode_ind, mcsa_out}, 16'd0);
    endtask

    initial begin
        logic [10:0] m_low = '0;
        logic        m_chan = 1'b0, m_ill = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;          // addr_en low: address 9 taken on next edge (R1)
        @(negedge clk);
        addr_en = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic [23:0] v;
            v = VEC[i];
            sel_sa = 1'b0;
            send(v[23:8], v[7], v[6], 1'b0);
            if (v[5]) begin
                m_low = v[18:8]; m_chan = v[7]; m_ill = v[6];
            end
            chk($sformatf("R6 xmit_n v%0d", i), {15'd0, xmit_n}, {15'd0, v[4]});
            chk($sformatf("R6 rcv_n v%0d", i), {15'd0, rcv_n}, {15'd0, v[3]});
            chk($sformatf("R7 bcast_n v%0d", i), {15'd0, bcast_n}, {15'd0, v[2]});
            chk($sformatf("R8 msg_err v%0d", i), {15'd0, msg_err}, {15'd0, v[1]});
            chk($sformatf("R5 chan v%0d", i), {15'd0, chan_a_out}, {15'd0, m_chan});
            chk($sformatf("R10 R2 last_cmd v%0d", i), last_cmd,
                {v[1], m_ill, !v[2], v[0], m_chan, m_low});
            chk($sformatf("R4 mode_ind v%0d", i), {15'd0, mode_ind}, {15'd0, v[0]});
            chk($sformatf("R3 mode code v%0d", i), {11'd0, mcsa_out}, {11'd0, m_low[4:0]});
            sel_sa = 1'b1;
            #2;
            chk($sformatf("R3 subaddr v%0d", i), {11'd0, mcsa_out}, {11'd0, m_low[9:5]});
            chk($sformatf("R4 mode_ind sel v%0d", i), {15'd0, mode_ind}, 16'd0);
        end
        sel_sa = 1'b0;

        // R1: pins change while enable is high: address 12 is not taken
        addr_in = 5'd12;
        send(16'h6021, 1'b0, 1'b0, 1'b0);
        chk("R1 R2 held address ignores 12", last_cmd, 16'hC881);
        // R1: load pulse takes address 12
        @(negedge clk); addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0;
        send(16'h6021, 1'b0, 1'b0, 1'b0);
        chk("R1 loaded address accepts", last_cmd, 16'h0021);
        chk("R6 rcv_n after load", {15'd0, rcv_n}, 16'd0);
        // R9: sequence error pulse
        @(negedge clk); seq_err = 1'b1;
        @(negedge clk); seq_err = 1'b0;
        chk("R9 seq_err sets msg_err", last_cmd, 16'h8021);
        @(negedge clk);
        chk("R12 error holds", {15'd0, msg_err}, 16'd1);
        send(16'h6021, 1'b1, 1'b0, 1'b0);
        chk("R8 legal command clears error", last_cmd, 16'h0821);
        send(16'h6021, 1'b0, 1'b0, 1'b1);
        chk("R9 seq_err with accept", {15'd0, msg_err}, 16'd1);
        // R11: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_reset();
        send(16'h6021, 1'b0, 1'b0, 1'b0);
        chk("R11 address cleared by reset", last_cmd, 16'h0000);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule